// File: doc/BRIEF.md
# Reciprocal / Gated Frequency Counter Core

This core measures an external signal against a 10 MHz reference. It uses two counters. The window counter is preloaded with a length and counts down. The tally counter adds up pulses while the window is open. One mode bit decides which signal drives which counter. In frequency mode the reference paces the window and the tally counts cycles of the external signal. In period mode the roles swap: the window lasts a fixed number of cycles of the external signal, and the tally counts reference cycles during that time.

The external signal and the reference both pass through a multi-flop synchroniser into the system clock domain. Each counter advances on a detected rising edge, so the system clock must run at least twice as fast as either signal. The window opens on a rising edge of the signal that paces it and closes on the edge where the window counter reaches zero. The host works through a small register port. It preloads both counters, writes the mode together with a start bit, polls a done flag and reads the tally. The host does the final arithmetic and accounts for wraps of the tally counter.

Top module: `fc_core`

## Requirements
- R1: After reset, the status word (address 0) reads 0, and the window counter (address 1) and the tally (address 2) both read 0.
- R2: In frequency mode (control bit 1 = 0), a start (control bit 0 = 1) with window preload G leaves in the tally, once done, its preload plus the number of external-signal rising edges seen during G reference periods.
- R3: In period mode (control bit 1 = 1), the tally gains the number of reference rising edges seen during G periods of the external signal.
- R4: The tally is 24 bits wide. Above 0xFFFFFF it wraps to 0 and keeps counting, with no saturation and no flag.
- R5: After an accepted start with a nonzero preload, status bit 1 (busy) reads 1 and status bit 0 (done) reads 0. When the window counter has used up its preload, the window closes, busy returns to 0, done becomes 1, and address 1 reads 0.
- R6: Once done is set, the tally holds its value until the next start. A new start clears done.
- R7: A start with a window preload of 0 sets done in the same cycle as the write. Busy stays 0 and the tally keeps its value.
- R8: While busy is 1, every register write is ignored. This covers the mode, start, window preload and tally preload.
- R9: While idle, a write to address 1 or address 2 is read back unchanged from that address. Status bit 2 reads back the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | 10 MHz reference, asynchronous to clk |
| sig_in | input | 1 | Signal under measurement, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control/status, 1 window counter, 2 tally |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for addr, combinational |

## Verification
The tally, window counter and status are all visible on the register port. A fault in the window state machine or in the edge routing therefore shows up as a wrong tally, or as done arriving early or late. That happens within one window length after start. A window that opens or closes one edge off changes the tally by a whole count, so the stimulus uses windows that are exact multiples of the counted period. Faults in the wrap or hold logic show at the next read of address 2.

// File: rtl/fc_pkg.sv
package fc_pkg;

    localparam int FC_CNT_W      = 24;
    localparam int FC_SYNC_DEPTH = 2;

    localparam int ST_DONE_BIT = 0;
    localparam int ST_BUSY_BIT = 1;
    localparam int ST_MODE_BIT = 2;

    localparam int CT_START_BIT = 0;
    localparam int CT_MODE_BIT  = 1;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_ARM  = 2'd1,
        GS_OPEN = 2'd2
    } gate_state_e;

    typedef enum logic {
        MODE_FREQ   = 1'b0,
        MODE_PERIOD = 1'b1
    } meas_mode_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_GATE  = 2'd1,
        RA_TALLY = 2'd2,
        RA_RSVD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic window_edge;
        logic tally_edge;
    } edge_route_t;

    function automatic edge_route_t route_edges(meas_mode_e m, logic ref_e, logic sig_e);
        edge_route_t r;
        if (m == MODE_FREQ) begin
            r.window_edge = ref_e;
            r.tally_edge  = sig_e;
        end else begin
            r.window_edge = sig_e;
            r.tally_edge  = ref_e;
        end
        return r;
    endfunction

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [DEPTH-1:0] chain_q;
    logic             last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], async_in};
            last_q  <= chain_q[DEPTH-1];
        end
    end

    assign rise = chain_q[DEPTH-1] & ~last_q;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/fc_tally.sv
module fc_tally #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (load_en) begin
            val_q <= load_val;
        end else if (inc) begin
            val_q <= val_q + 1'b1;
        end
    end

    assign value = val_q;

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !load_en && val_q == TOP) |=> (val_q == '0));

    // R6
    tally_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load_en) |=> $stable(val_q));

endmodule

// File: rtl/fc_window.sv
module fc_window
    import fc_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         start,
    input  logic         window_edge,
    output logic         is_open,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] remaining
);
    gate_state_e  state_q;
    logic [W-1:0] left_q;
    logic         done_q;
    logic         last_edge;

    assign last_edge = (left_q == {{(W-1){1'b0}}, 1'b1});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (load_en) begin
                        left_q <= load_val;
                    end
                    if (start) begin
                        if (left_q == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q  <= 1'b0;
                            state_q <= GS_ARM;
                        end
                    end
                end
                GS_ARM: begin
                    if (window_edge) begin
                        state_q <= GS_OPEN;
                    end
                end
                GS_OPEN: begin
                    if (window_edge) begin
                        left_q <= left_q - 1'b1;
                        if (last_edge) begin
                            state_q <= GS_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= GS_IDLE;
            endcase
        end
    end

    assign is_open   = (state_q == GS_OPEN);
    assign busy      = (state_q != GS_IDLE);
    assign done      = done_q;
    assign remaining = left_q;

    // R5
    close_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_OPEN && window_edge && last_edge) |=> (done && !busy && left_q == '0));

    // R7
    zero_preload_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GS_IDLE && start && !load_en && left_q == '0) |=> (done && !busy));

    // R5
    busy_not_done_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

endmodule

// File: rtl/fc_core.sv
module fc_core
    import fc_pkg::*;
#(
    parameter int CNT_W      = FC_CNT_W,
    parameter int SYNC_DEPTH = FC_SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             sig_in,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata
);
    localparam int ST_PAD = CNT_W - 3;

    logic        ref_rise, sig_rise;
    meas_mode_e  mode_q;
    edge_route_t route;
    logic        win_open, win_busy, win_done;
    logic [CNT_W-1:0] win_left, tally_val;
    logic        wr_ok, start_req, win_load, tally_load;
    reg_addr_e   ra;

    fc_edge_sync #(.DEPTH(SYNC_DEPTH)) u_ref_sync (
        .clk(clk), .rst(rst), .async_in(ref_in), .rise(ref_rise));

    fc_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sig_sync (
        .clk(clk), .rst(rst), .async_in(sig_in), .rise(sig_rise));

    assign ra         = reg_addr_e'(addr);
    assign wr_ok      = wr_en && !win_busy;
    assign start_req  = wr_ok && ra == RA_CTRL && wdata[CT_START_BIT];
    assign win_load   = wr_ok && ra == RA_GATE;
    assign tally_load = wr_ok && ra == RA_TALLY;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FREQ;
        end else if (wr_ok && ra == RA_CTRL) begin
            mode_q <= meas_mode_e'(wdata[CT_MODE_BIT]);
        end
    end

    assign route = route_edges(mode_q, ref_rise, sig_rise);

    fc_window #(.W(CNT_W)) u_window (
        .clk(clk), .rst(rst),
        .load_en(win_load), .load_val(wdata),
        .start(start_req), .window_edge(route.window_edge),
        .is_open(win_open), .busy(win_busy), .done(win_done),
        .remaining(win_left));

    fc_tally #(.W(CNT_W)) u_tally (
        .clk(clk), .rst(rst),
        .load_en(tally_load), .load_val(wdata),
        .inc(win_open && route.tally_edge),
        .value(tally_val));

    always_comb begin
        unique case (ra)
            RA_CTRL:  rdata = {{ST_PAD{1'b0}}, logic'(mode_q), win_busy, win_done};
            RA_GATE:  rdata = win_left;
            RA_TALLY: rdata = tally_val;
            default:  rdata = '0;
        endcase
    end

    // R8
    busy_mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (win_busy && wr_en) |=> $stable(mode_q));

    // R8
    busy_tally_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (win_busy && !win_open) |=> $stable(tally_val));

endmodule

// File: tb/tb_fc_core.sv
module tb_fc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0, sig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    int ref_per = 4, sig_per = 10;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fc_core dut (.clk(clk), .rst(rst), .ref_in(ref_in), .sig_in(sig_in),
                 .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

    initial begin
        int rc = 0, sc = 1;
        forever begin
            @(negedge clk);
            rc++; if (rc >= ref_per) rc = 0;
            sc++; if (sc >= sig_per) sc = 0;
            ref_in = (rc < ref_per / 2);
            sig_in = (sc < sig_per / 2);
        end
    end

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [23:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [23:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_done(string req);
        logic [23:0] st;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, st);
            if (st[0]) return;
        end
        check(req, st, 24'h1);
    endtask

    task automatic measure(string req, bit period, int rp, int sp,
                           logic [23:0] gate, logic [23:0] pre, logic [23:0] exp);
        logic [23:0] v;
        ref_per = rp; sig_per = sp;
        wr(2'd1, gate);
        wr(2'd2, pre);
        wr(2'd0, {22'd0, period, 1'b1});
        wait_done(req);
        rd(2'd2, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        logic [23:0] v;
        rd(2'd0, v); check("R1 status", v, 24'h0);
        rd(2'd1, v); check("R1 window", v, 24'h0);
        rd(2'd2, v); check("R1 tally", v, 24'h0);
    endtask

    task automatic t_readback();
        logic [23:0] v;
        wr(2'd1, 24'hABCDE); rd(2'd1, v); check("R9 window", v, 24'hABCDE);
        wr(2'd2, 24'h12345); rd(2'd2, v); check("R9 tally", v, 24'h12345);
        wr(2'd0, 24'h2);     rd(2'd0, v); check("R9 mode", v, 24'h4);
        wr(2'd0, 24'h0);
    endtask

    task automatic t_freq();
        measure("R2 f4/10", 1'b0, 4, 10, 24'd10, 24'd0, 24'd4);
        measure("R2 f6/9",  1'b0, 6, 9,  24'd30, 24'd0, 24'd20);
        measure("R2 preload", 1'b0, 4, 8, 24'd6, 24'd100, 24'd103);
    endtask

    task automatic t_period();
        measure("R3 p20/4", 1'b1, 4, 20, 24'd5, 24'd0, 24'd25);
        measure("R3 p14/7", 1'b1, 7, 14, 24'd6, 24'd0, 24'd12);
    endtask

    task automatic t_wrap();
        measure("R4 wrap", 1'b0, 4, 10, 24'd10, 24'hFFFFFE, 24'd2);
    endtask

    task automatic t_flags();
        logic [23:0] v;
        ref_per = 4; sig_per = 10;
        wr(2'd1, 24'd20);
        wr(2'd2, 24'd0);
        wr(2'd0, 24'h1);
        rd(2'd0, v); check("R5 busy", v, 24'h2);
        rd(2'd0, v); check("R6 done cleared", v & 24'h1, 24'h0);
        wait_done("R5 done");
        rd(2'd0, v); check("R5 idle+done", v, 24'h1);
        rd(2'd1, v); check("R5 window used", v, 24'h0);
        rd(2'd2, v); check("R5 tally", v, 24'd8);
        repeat (60) @(negedge clk);
        rd(2'd2, v); check("R6 hold", v, 24'd8);
    endtask

    task automatic t_zero();
        logic [23:0] v;
        wr(2'd1, 24'd0);
        wr(2'd2, 24'd77);
        wr(2'd0, 24'h1);
        rd(2'd0, v); check("R7 done at once", v, 24'h1);
        rd(2'd2, v); check("R7 tally kept", v, 24'd77);
    endtask

    task automatic t_busy_ignore();
        logic [23:0] v;
        ref_per = 4; sig_per = 20;
        wr(2'd1, 24'd5);
        wr(2'd2, 24'd0);
        wr(2'd0, 24'h3);
        wr(2'd0, 24'h1);
        wr(2'd2, 24'd123);
        wr(2'd1, 24'd3);
        wait_done("R8 done");
        rd(2'd2, v); check("R8 tally", v, 24'd25);
        rd(2'd0, v); check("R8 mode kept", v, 24'h5);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_freq();
        t_period();
        t_wrap();
        t_flags();
        t_zero();
        t_busy_ignore();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule